// File: doc/BRIEF.md
# 32-bit Integer Arithmetic and Logic Unit

This block is the combinational arithmetic and logic unit of a simple RISC integer pipeline. It takes two 32-bit operands and a 4-bit operation code, and returns a 32-bit result, a carry-out and a signed-overflow flag in the same cycle. It does addition, subtraction, four bitwise operations and two set-less-than comparisons. All of them use one shared adder, and subtraction runs on that adder as A + ~B + 1.

The operation code is the low four bits of the instruction's function field. Signed and unsigned add and subtract give the same result and carry. They differ only in whether the overflow flag may rise. The overflow flag is reported to the pipeline and never trapped here. The two comparisons use different rules. The signed one combines the sign of the difference with the overflow. The unsigned one uses the borrow.

Top module: `int_alu`

## Requirements
- R1: Code 4'b0000 (signed add) and 4'b0001 (unsigned add) give result = (A + B) mod 2^32, and carry = bit 32 of the full sum.
- R2: Code 4'b0010 (signed subtract) and 4'b0011 (unsigned subtract) give result = (A - B) mod 2^32. Carry is 1 exactly when no borrow occurs, that is when A >= B as unsigned numbers.
- R3: In codes 4'b0000 and 4'b0010 only, overflow is 1 exactly when the true signed result does not fit in 32 bits. For an add this means the operands share a sign and the result's sign differs. For a subtract it means the operands' signs differ and the result's sign differs from A's.
- R4: Codes 4'b0001 and 4'b0011 never set overflow, even on operands that overflow under codes 4'b0000 and 4'b0010.
- R5: Codes 4'b0100 (A AND B), 4'b0101 (A OR B), 4'b0110 (A XOR B) and 4'b0111 (NOT (A OR B)) give the bitwise result. Carry and overflow are 0 in these codes.
- R6: Code 4'b1010 gives result 1 when A < B as signed numbers and 0 otherwise. This holds also when A - B overflows. Bits 31..1 of the result are 0, and carry and overflow are 0.
- R7: Code 4'b1011 gives result 1 when A < B as unsigned numbers and 0 otherwise. Bits 31..1 are 0, and carry and overflow are 0.
- R8: Every other code (4'b1000, 4'b1001, 4'b1100 through 4'b1111) gives result 0 with carry and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| mode | input | 4 | Operation code (low bits of the function field) |
| result | output | 32 | Operation result |
| carry | output | 1 | Carry-out of the adder for add and subtract codes, else 0 |
| overflow | output | 1 | Signed overflow for signed add and subtract, else 0 |

## Verification
The adder is driven with small values and with a full carry ripple (all ones plus one), which separates a broken carry chain from a broken sum bit. Operand pairs at the signed limits (0x7FFFFFFF, 0x80000000) are run through both the signed and unsigned add and subtract codes. These pairs tell the overflow rule apart from the carry, and show that the unsigned codes keep the flag low. The comparisons use pairs where the signed and unsigned orders disagree, and pairs where A - B overflows, so that a comparator reading only the sign bit is caught. Every undefined code is applied with non-zero operands.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        OP_ADD  = 4'b0000,
        OP_ADDU = 4'b0001,
        OP_SUB  = 4'b0010,
        OP_SUBU = 4'b0011,
        OP_AND  = 4'b0100,
        OP_OR   = 4'b0101,
        OP_XOR  = 4'b0110,
        OP_NOR  = 4'b0111,
        OP_SLT  = 4'b1010,
        OP_SLTU = 4'b1011
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'b00,
        BW_OR  = 2'b01,
        BW_XOR = 2'b10,
        BW_NOR = 2'b11
    } bitwise_sel_e;

endpackage

// File: rtl/int_alu_adder.sv
module int_alu_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_eff,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         c_msb_in
);
    logic [W:0] c_chain;

    assign c_chain[0] = cin;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic prop;
            logic gen;
            assign prop         = a[i] ^ b_eff[i];
            assign gen          = a[i] & b_eff[i];
            assign sum[i]       = prop ^ c_chain[i];
            assign c_chain[i+1] = gen | (prop & c_chain[i]);
        end
    endgenerate

    assign cout     = c_chain[W];
    assign c_msb_in = c_chain[W-1];

    always_comb begin
        AST_ADDER_SUM: assert ({cout, sum} == ({1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin})); // R1
    end

endmodule

// File: rtl/int_alu_bitwise.sv
module int_alu_bitwise
    import int_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  bitwise_sel_e  sel,
    output logic [W-1:0]  y
);
    always_comb begin
        unique case (sel)
            BW_AND:  y = a & b;
            BW_OR:   y = a | b;
            BW_XOR:  y = a ^ b;
            default: y = ~(a | b);
        endcase
    end

    always_comb begin
        if (sel == BW_NOR) begin
            AST_NOR_DISJOINT: assert ((y & (a | b)) == '0); // R5
        end
    end

endmodule

// File: rtl/int_alu_compare.sv
module int_alu_compare #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         diff_sign,
    input  logic         ovf_raw,
    input  logic         cout,
    input  logic         active,
    output logic         lt_s,
    output logic         lt_u
);
    assign lt_s = diff_sign ^ ovf_raw;
    assign lt_u = ~cout;

    always_comb begin
        if (active) begin
            AST_SIGNED_ORDER:   assert (lt_s == ($signed(a) < $signed(b))); // R6
            AST_UNSIGNED_ORDER: assert (lt_u == (a < b));                   // R7
        end
    end

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [MODE_W-1:0] mode,
    output logic [W-1:0]      result,
    output logic              carry,
    output logic              overflow
);
    typedef struct packed {
        logic [W-1:0] value;
        logic         carry;
        logic         ovf;
    } alu_out_t;

    alu_op_e      op;
    logic         use_sub;
    logic         is_cmp;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         cout;
    logic         c_msb_in;
    logic         ovf_raw;
    logic [W-1:0] bw_y;
    logic         lt_s;
    logic         lt_u;
    alu_out_t     res_d;

    assign op      = alu_op_e'(mode);
    assign is_cmp  = (op == OP_SLT) || (op == OP_SLTU);
    assign use_sub = (op == OP_SUB) || (op == OP_SUBU) || is_cmp;
    assign b_eff   = use_sub ? ~b : b;
    assign ovf_raw = cout ^ c_msb_in;

    int_alu_adder #(.W(W)) u_adder (
        .a        (a),
        .b_eff    (b_eff),
        .cin      (use_sub),
        .sum      (sum),
        .cout     (cout),
        .c_msb_in (c_msb_in)
    );

    int_alu_bitwise #(.W(W)) u_bitwise (
        .a   (a),
        .b   (b),
        .sel (bitwise_sel_e'(mode[1:0])),
        .y   (bw_y)
    );

    int_alu_compare #(.W(W)) u_compare (
        .a         (a),
        .b         (b),
        .diff_sign (sum[W-1]),
        .ovf_raw   (ovf_raw),
        .cout      (cout),
        .active    (is_cmp),
        .lt_s      (lt_s),
        .lt_u      (lt_u)
    );

    always_comb begin
        res_d = '0;
        case (op)
            OP_ADD, OP_SUB: begin
                res_d.value = sum;
                res_d.carry = cout;
                res_d.ovf   = ovf_raw;
            end
            OP_ADDU, OP_SUBU: begin
                res_d.value = sum;
                res_d.carry = cout;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOR: begin
                res_d.value = bw_y;
            end
            OP_SLT: begin
                res_d.value = {{(W-1){1'b0}}, lt_s};
            end
            OP_SLTU: begin
                res_d.value = {{(W-1){1'b0}}, lt_u};
            end
            default: res_d = '0;
        endcase
    end

    assign result   = res_d.value;
    assign carry    = res_d.carry;
    assign overflow = res_d.ovf;

    always_comb begin
        if (op == OP_ADD && overflow) begin
            AST_ADD_OVF_SIGNS: assert ((a[W-1] == b[W-1]) && (result[W-1] != a[W-1])); // R3
        end
        if (op == OP_SUB && overflow) begin
            AST_SUB_OVF_SIGNS: assert ((a[W-1] != b[W-1]) && (result[W-1] != a[W-1])); // R3
        end
        if (op == OP_ADDU || op == OP_SUBU) begin
            AST_NO_UNSIGNED_OVF: assert (!overflow); // R4
        end
        if (mode[3:2] == 2'b01) begin
            AST_LOGIC_FLAGS_LOW: assert (!carry && !overflow); // R5
        end
        if (is_cmp) begin
            AST_CMP_UPPER_ZERO: assert ((result[W-1:1] == '0) && !carry && !overflow); // R6 R7
        end
        if (mode[3] && !is_cmp) begin
            AST_UNDEF_CODE_ZERO: assert ((result == '0) && !carry && !overflow); // R8
        end
    end

endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a   = '0;
    logic [31:0] b   = '0;
    logic [3:0]  mode = '0;
    logic [31:0] result;
    logic        carry;
    logic        overflow;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    int_alu u0 (
        .a        (a),
        .b        (b),
        .mode     (mode),
        .result   (result),
        .carry    (carry),
        .overflow (overflow)
    );

    // Expected values written from the requirement text.
    function automatic logic [33:0] expect_of(input logic [3:0] m, input logic [31:0] x, input logic [31:0] y);
        logic [32:0] full;
        logic [31:0] s;
        logic        c;
        logic        v;
        s = '0; c = 1'b0; v = 1'b0;
        case (m)
            4'b0000, 4'b0001: begin
                full = {1'b0, x} + {1'b0, y};
                s = full[31:0];
                c = full[32];
                if (m == 4'b0000) v = (x[31] == y[31]) && (s[31] != x[31]);
            end
            4'b0010, 4'b0011: begin
                s = x - y;
                c = (x >= y);
                if (m == 4'b0010) v = (x[31] != y[31]) && (s[31] != x[31]);
            end
            4'b0100: s = x & y;
            4'b0101: s = x | y;
            4'b0110: s = x ^ y;
            4'b0111: s = ~(x | y);
            4'b1010: s = {31'd0, ($signed(x) < $signed(y))};
            4'b1011: s = {31'd0, (x < y)};
            default: s = '0;
        endcase
        return {s, c, v};
    endfunction

    task automatic apply(input string req, input logic [3:0] m, input logic [31:0] x, input logic [31:0] y);
        logic [33:0] e;
        @(posedge clk);
        mode = m; a = x; b = y;
        @(negedge clk);
        e = expect_of(m, x, y);
        checks++;
        if ({result, carry, overflow} !== e) begin
            failures++;
            $display("FAIL %s mode=%b a=%h b=%h actual=%h/%b/%b expected=%h/%b/%b",
                     req, m, x, y, result, carry, overflow, e[33:2], e[1], e[0]);
        end
    endtask

    task automatic t_idle;
        @(negedge clk);
        checks++;
        if ({result, carry, overflow} !== 34'd0) begin
            failures++;
            $display("FAIL R1 idle actual=%h/%b/%b expected=0/0/0", result, carry, overflow);
        end
    endtask

    task automatic t_add;
        apply("R1", 4'b0000, 32'd5, 32'd7);
        apply("R1", 4'b0000, 32'hFFFF_FFFF, 32'd1);
        apply("R1", 4'b0001, 32'h8000_0000, 32'h8000_0000);
        apply("R1", 4'b0001, 32'h1234_5678, 32'h0FED_CBA9);
    endtask

    task automatic t_sub;
        apply("R2", 4'b0010, 32'd10, 32'd3);
        apply("R2", 4'b0010, 32'd3, 32'd10);
        apply("R2", 4'b0011, 32'd0, 32'd1);
        apply("R2", 4'b0011, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    endtask

    task automatic t_overflow;
        apply("R3", 4'b0000, 32'h7FFF_FFFF, 32'd1);
        apply("R3", 4'b0000, 32'h8000_0000, 32'hFFFF_FFFF);
        apply("R3", 4'b0000, 32'h7FFF_FFFF, 32'h8000_0000);
        apply("R3", 4'b0010, 32'h8000_0000, 32'd1);
        apply("R3", 4'b0010, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        apply("R3", 4'b0010, 32'd0, 32'h8000_0000);
    endtask

    task automatic t_unsigned;
        apply("R4", 4'b0001, 32'h7FFF_FFFF, 32'd1);
        apply("R4", 4'b0001, 32'h8000_0000, 32'hFFFF_FFFF);
        apply("R4", 4'b0011, 32'h8000_0000, 32'd1);
        apply("R4", 4'b0011, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_logic;
        for (int m = 4; m < 8; m++) begin
            apply("R5", 4'(m), 32'hF0F0_AAAA, 32'hFF00_5555);
            apply("R5", 4'(m), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        end
    endtask

    task automatic t_slt;
        apply("R6", 4'b1010, 32'hFFFF_FFFF, 32'd1);
        apply("R6", 4'b1010, 32'd1, 32'hFFFF_FFFF);
        apply("R6", 4'b1010, 32'h8000_0000, 32'h7FFF_FFFF);
        apply("R6", 4'b1010, 32'h7FFF_FFFF, 32'h8000_0000);
        apply("R6", 4'b1010, 32'd42, 32'd42);
    endtask

    task automatic t_sltu;
        apply("R7", 4'b1011, 32'hFFFF_FFFF, 32'd1);
        apply("R7", 4'b1011, 32'd1, 32'hFFFF_FFFF);
        apply("R7", 4'b1011, 32'd42, 32'd42);
        apply("R7", 4'b1011, 32'd0, 32'd1);
    endtask

    task automatic t_undefined;
        for (int m = 8; m < 16; m++) begin
            if (m != 10 && m != 11) apply("R8", 4'(m), 32'h7FFF_FFFF, 32'h8000_0001);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_add();
        t_sub();
        t_overflow();
        t_unsigned();
        t_logic();
        t_slt();
        t_sltu();
        t_undefined();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule